// File: doc/BRIEF.md
# Bus Idle Wait Timer

This block gates the start of a new outgoing message on a shared single-wire consumer-electronics control bus. Before a transmitter may pull the line, the line must have stayed released for a minimum idle span. The block measures that span in half nominal bit periods. It counts pulses on a prescaled half-bit tick while the line is high, and restarts from zero whenever the line is seen low. When the span has been met and a start-of-message request is pending, it raises a grant to the transmitter.

The idle span comes from a 3-bit selector. A nonzero selector value n asks for 0.5 + (n-1) bit periods, which is 2n-1 half-bit ticks. A zero selector picks a default that depends on what last happened on the bus. A node that takes the bus after a foreign message, or after reset, waits 7 bit periods. It waits 5 bit periods after its own successful transmission and 3 bit periods before retrying a failed one. A start-mode bit chooses when the count begins. In one mode it begins at the software start request. In the other it begins on its own at the end of every transmitted or received message, so that a later request can be granted at once. An end-of-message request is latched as well, so that a one-byte message may post its end marker before its start marker.

Top module: `sft_timer`

## Requirements
- R1: Out of reset, grant_o and eom_pend_o are 0.
- R2: With sel_i = n (1..7) and start_mode_i = 0, grant_o rises right after the (2n-1)th half_tick_i pulse that follows the som_req_i pulse, with the line held high, and not before.
- R3: With sel_i = 0, after reset, after a peer_done_i pulse, or after enable_i is dropped, the wait is 14 half-bit ticks.
- R4: With sel_i = 0, after an own_ok_i pulse the wait is 10 half-bit ticks.
- R5: With sel_i = 0, after an own_fail_i pulse the wait is 6 half-bit ticks.
- R6: With start_mode_i = 0, end-of-message events do not start the count and ticks before som_req_i do not count; the full wait runs from the request.
- R7: With start_mode_i = 1, each own_ok_i, own_fail_i or peer_done_i pulse restarts the count from zero; if the wait is already met when som_req_i arrives, grant_o rises one cycle later.
- R8: A low line_i in any cycle clears the count to zero; grant_o is 0 in the cycle after it, and the full wait must then run again.
- R9: Once raised, grant_o stays 1 while the line stays high and no new start or end event occurs, until a tx_started_i pulse or enable_i = 0 clears it in the next cycle.
- R10: An eom_req_i pulse sets eom_pend_o, which stays 1 across a later som_req_i and through the grant, and clears after tx_started_i; both requests may be pending together.
- R11: While enable_i is 0, every request, tick and event is ignored: grant_o and eom_pend_o stay 0 and no request survives the re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; 0 clears pending requests, count and history |
| half_tick_i | input | 1 | One-cycle pulse per half nominal bit period |
| line_i | input | 1 | Sampled bus level, 1 = released |
| sel_i | input | 3 | Idle-span selector, 0 = history default |
| start_mode_i | input | 1 | 0: count from start request; 1: count from end of message |
| som_req_i | input | 1 | Start-of-message request pulse |
| eom_req_i | input | 1 | End-of-message request pulse |
| own_ok_i | input | 1 | Own transmission ended successfully |
| own_fail_i | input | 1 | Own transmission ended in error |
| peer_done_i | input | 1 | Reception of a message ended |
| tx_started_i | input | 1 | Transmitter has begun driving the message |
| grant_o | output | 1 | Transmitter may begin |
| eom_pend_o | output | 1 | End-of-message request pending |

## Verification
A wrong count or wrong target shows as grant_o rising one or more half-bit ticks early or late, so each sweep point checks the grant after every single tick of the wait. A history register stuck or updated by the wrong event shows only with sel_i = 0, as a 14/10/6 tick wait swapped for another, and it appears in the first grant after that event. A count that is not cleared by a low line, or a request latch that survives a disable or a start, shows within one cycle as a grant that stays high when it should drop.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    HIST_NEW   = 2'd0,
    HIST_OWN   = 2'd1,
    HIST_RETRY = 2'd2
  } sft_hist_e;
endpackage

// File: rtl/sft_history.sv
module sft_history
  import sft_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clear_i,
  input  logic      own_ok_i,
  input  logic      own_fail_i,
  input  logic      peer_done_i,
  output sft_hist_e hist_o
);
  sft_hist_e hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hist_q <= HIST_NEW;
    else if (clear_i)     hist_q <= HIST_NEW;
    else if (own_fail_i)  hist_q <= HIST_RETRY;
    else if (own_ok_i)    hist_q <= HIST_OWN;
    else if (peer_done_i) hist_q <= HIST_NEW;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/sft_target.sv
module sft_target
  import sft_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 4,
  parameter int DEF_NEW   = 7,
  parameter int DEF_OWN   = 5,
  parameter int DEF_RETRY = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  sft_hist_e        hist_i,
  output logic [CNT_W-1:0] target_o
);
  localparam logic [CNT_W-1:0] HALF_NEW   = CNT_W'(2 * DEF_NEW);
  localparam logic [CNT_W-1:0] HALF_OWN   = CNT_W'(2 * DEF_OWN);
  localparam logic [CNT_W-1:0] HALF_RETRY = CNT_W'(2 * DEF_RETRY);

  always_comb begin
    if (sel_i != '0) begin
      // n -> 0.5 + (n-1) bits = 2n-1 half bits
      target_o = CNT_W'({sel_i, 1'b0}) - CNT_W'(1);
    end else begin
      unique case (hist_i)
        HIST_OWN:   target_o = HALF_OWN;
        HIST_RETRY: target_o = HALF_RETRY;
        default:    target_o = HALF_NEW;
      endcase
    end
  end
endmodule

// File: rtl/sft_idle_counter.sv
module sft_idle_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             line_i,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clear_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (!line_i)                        cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign running_o = run_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/sft_req_latch.sv
module sft_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (clear_i) pend_q <= 1'b0;
    else              pend_q <= (pend_q & ~take_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sft_timer.sv
module sft_timer
  import sft_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int DEF_NEW   = 7,
  parameter int DEF_OWN   = 5,
  parameter int DEF_RETRY = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             half_tick_i,
  input  logic             line_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             start_mode_i,
  input  logic             som_req_i,
  input  logic             eom_req_i,
  input  logic             own_ok_i,
  input  logic             own_fail_i,
  input  logic             peer_done_i,
  input  logic             tx_started_i,
  output logic             grant_o,
  output logic             eom_pend_o
);
  localparam int PROG_MAX = 2 * ((1 << SEL_W) - 1) - 1;
  localparam int DEF_MAX  = 2 * ((DEF_NEW > DEF_OWN) ?
                                 ((DEF_NEW > DEF_RETRY) ? DEF_NEW : DEF_RETRY) :
                                 ((DEF_OWN > DEF_RETRY) ? DEF_OWN : DEF_RETRY));
  localparam int HALF_MAX = (PROG_MAX > DEF_MAX) ? PROG_MAX : DEF_MAX;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  logic             clear;
  logic             ok_ev, fail_ev, peer_ev, any_end;
  logic             som_ev, eom_ev, take_ev, start_ev;
  logic             running, som_pend;
  logic [CNT_W-1:0] cnt, target;
  sft_hist_e        hist;

  assign clear   = ~enable_i;
  assign ok_ev   = enable_i & own_ok_i;
  assign fail_ev = enable_i & own_fail_i;
  assign peer_ev = enable_i & peer_done_i;
  assign any_end = ok_ev | fail_ev | peer_ev;
  assign som_ev  = enable_i & som_req_i;
  assign eom_ev  = enable_i & eom_req_i;
  assign take_ev = enable_i & tx_started_i;
  assign start_ev = start_mode_i ? any_end : som_ev;

  sft_history u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .own_ok_i    (ok_ev),
    .own_fail_i  (fail_ev),
    .peer_done_i (peer_ev),
    .hist_o      (hist)
  );

  sft_target #(
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W),
    .DEF_NEW   (DEF_NEW),
    .DEF_OWN   (DEF_OWN),
    .DEF_RETRY (DEF_RETRY)
  ) u_target (
    .sel_i    (sel_i),
    .hist_i   (hist),
    .target_o (target)
  );

  sft_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .start_i   (start_ev),
    .stop_i    (take_ev),
    .tick_i    (half_tick_i),
    .line_i    (line_i),
    .running_o (running),
    .cnt_o     (cnt)
  );

  sft_req_latch u_som (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .set_i   (som_ev),
    .take_i  (take_ev),
    .pend_o  (som_pend)
  );

  sft_req_latch u_eom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .set_i   (eom_ev),
    .take_i  (take_ev),
    .pend_o  (eom_pend_o)
  );

  assign grant_o = running & som_pend & (cnt >= target);
endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             line_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             start_mode_i,
  input logic             som_req_i,
  input logic             eom_req_i,
  input logic             own_ok_i,
  input logic             own_fail_i,
  input logic             peer_done_i,
  input logic             tx_started_i,
  input logic             grant_o,
  input logic             eom_pend_o
);
  assert_disable_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!grant_o && !eom_pend_o));

  assert_low_line_drops_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_i && enable_i) |=> !grant_o);

  assert_start_drops_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_started_i && enable_i) |=> !grant_o);

  assert_grant_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && enable_i && line_i && !tx_started_i && !som_req_i &&
     !own_ok_i && !own_fail_i && !peer_done_i)
    |=> (grant_o || !$stable(sel_i) || !$stable(start_mode_i)));

  assert_eom_latched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_req_i && enable_i) |=> eom_pend_o);

  assert_eom_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_pend_o && enable_i && !tx_started_i) |=> eom_pend_o);
endmodule

bind sft_timer sft_timer_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_sft_timer.sv
module sim_sft_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       half_tick_i = 1'b0;
  logic       line_i = 1'b1;
  logic [2:0] sel_i = 3'd0;
  logic       start_mode_i = 1'b0;
  logic       som_req_i = 1'b0;
  logic       eom_req_i = 1'b0;
  logic       own_ok_i = 1'b0;
  logic       own_fail_i = 1'b0;
  logic       peer_done_i = 1'b0;
  logic       tx_started_i = 1'b0;
  logic       grant_o;
  logic       eom_pend_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sft_timer u0 (.*);

  // history codes: 0 new initiator, 1 after own success, 2 retry
  function automatic int want_half(input int sel, input int hist);
    if (sel != 0) return 2 * sel - 1;
    case (hist)
      1: return 10;
      2: return 6;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic tick;
    half_tick_i = 1'b1; @(negedge clk_i); half_tick_i = 1'b0;
  endtask

  task automatic som;
    som_req_i = 1'b1; @(negedge clk_i); som_req_i = 1'b0;
  endtask

  task automatic eom;
    eom_req_i = 1'b1; @(negedge clk_i); eom_req_i = 1'b0;
  endtask

  task automatic started;
    tx_started_i = 1'b1; @(negedge clk_i); tx_started_i = 1'b0;
  endtask

  task automatic ev_ok;
    own_ok_i = 1'b1; @(negedge clk_i); own_ok_i = 1'b0;
  endtask

  task automatic ev_fail;
    own_fail_i = 1'b1; @(negedge clk_i); own_fail_i = 1'b0;
  endtask

  task automatic ev_peer;
    peer_done_i = 1'b1; @(negedge clk_i); peer_done_i = 1'b0;
  endtask

  // tick through a wait of w half bits, checking grant after every tick
  task automatic run_wait(input int w, input string req);
    for (int t = 1; t <= w + 2; t++) begin
      tick;
      chk(grant_o, (t >= w), req);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    idle(2);
    chk(grant_o, 1'b0, "R1 grant");
    chk(eom_pend_o, 1'b0, "R1 eom");
    rst_ni = 1'b1;
    idle(1);
    enable_i = 1'b1;
    idle(1);
    chk(grant_o, 1'b0, "R1 grant after release");

    // R3: default after reset
    sel_i = 3'd0; start_mode_i = 1'b0;
    som;
    run_wait(want_half(0, 0), "R3 reset default");
    started;
    chk(grant_o, 1'b0, "R9 cleared by start");

    // R2: programmed sweep, count from request
    for (int n = 1; n < 8; n++) begin
      sel_i = 3'(n);
      som;
      run_wait(want_half(n, 0), "R2 programmed wait");
      started;
      chk(grant_o, 1'b0, "R9 cleared by start");
    end

    // R4, R5, R3 history defaults
    sel_i = 3'd0;
    ev_ok; som;
    run_wait(want_half(0, 1), "R4 own success default");
    started;
    ev_fail; som;
    run_wait(want_half(0, 2), "R5 retry default");
    started;
    ev_peer; som;
    run_wait(want_half(0, 0), "R3 peer default");
    started;

    // R6: mode 0 ignores ticks before request and end events as start
    ev_ok;
    for (int i = 0; i < 20; i++) begin
      tick;
      chk(grant_o, 1'b0, "R6 no request no grant");
    end
    som;
    run_wait(want_half(0, 1), "R6 count from request");
    started;

    // R7: mode 1 sweep, count from end of message
    start_mode_i = 1'b1;
    for (int n = 1; n < 8; n++) begin
      sel_i = 3'(n);
      ev_peer;
      for (int i = 0; i < want_half(n, 0) - 1; i++) tick;
      som;
      chk(grant_o, 1'b0, "R7 one tick short");
      tick;
      chk(grant_o, 1'b1, "R7 wait met");
      started;
      ev_peer;
      for (int i = 0; i < want_half(n, 0); i++) tick;
      chk(grant_o, 1'b0, "R7 no request yet");
      som;
      chk(grant_o, 1'b1, "R7 immediate grant");
      started;
    end
    // R7: end event restarts count
    sel_i = 3'd3;
    ev_peer;
    tick; tick; tick;
    ev_ok;
    som;
    run_wait(want_half(3, 0), "R7 restart on end event");
    started;
    start_mode_i = 1'b0;

    // R8: low line clears count
    sel_i = 3'd4;
    som;
    for (int i = 0; i < 5; i++) tick;
    line_i = 1'b0; @(negedge clk_i); line_i = 1'b1;
    run_wait(want_half(4, 0), "R8 restart after low");
    line_i = 1'b0; @(negedge clk_i);
    chk(grant_o, 1'b0, "R8 low drops grant");
    line_i = 1'b1;
    run_wait(want_half(4, 0), "R8 full rerun");

    // R9: grant held while idle, cleared by disable
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) tick; else idle(1);
      chk(grant_o, 1'b1, "R9 held");
    end
    enable_i = 1'b0; @(negedge clk_i);
    chk(grant_o, 1'b0, "R9 disable clears");
    enable_i = 1'b1; idle(1);

    // R10: eom before som, both pending
    sel_i = 3'd1;
    eom;
    chk(eom_pend_o, 1'b1, "R10 eom latched");
    chk(grant_o, 1'b0, "R10 no grant on eom");
    som;
    chk(eom_pend_o, 1'b1, "R10 eom kept over som");
    tick;
    chk(grant_o, 1'b1, "R10 grant with eom pending");
    chk(eom_pend_o, 1'b1, "R10 eom kept over grant");
    started;
    chk(eom_pend_o, 1'b0, "R10 eom cleared by start");

    // R11: disabled block ignores everything, history reset
    sel_i = 3'd0;
    ev_ok;
    enable_i = 1'b0;
    som; eom; ev_fail;
    for (int i = 0; i < 20; i++) begin
      tick;
      chk(grant_o, 1'b0, "R11 disabled grant");
      chk(eom_pend_o, 1'b0, "R11 disabled eom");
    end
    enable_i = 1'b1;
    idle(1);
    for (int i = 0; i < 20; i++) tick;
    chk(grant_o, 1'b0, "R11 request dropped");
    chk(eom_pend_o, 1'b0, "R11 eom dropped");
    som;
    run_wait(want_half(0, 0), "R3 default after disable");
    started;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule